// File: doc/BRIEF.md
# Mixed-Sign Integer Multiplier

This block multiplies two 16-bit integers and returns their 32-bit product one clock after the request. Each operand has its own signedness flag, so one unit covers signed by signed, unsigned by unsigned, and both mixed orderings. Before the multiply, each operand is widened by one bit: a signed operand by copying its top bit, and an unsigned operand by prepending a zero. A single signed 17-by-17 multiplier then forms the product, and the low 32 bits of that product are the result. These bits are exact for every sign pairing.

A request is a cycle with `reqValid` high. In the following cycle `prodValid` is high and `product` holds the result. In a cycle with no request, `prodValid` is low and `product` keeps its last value. A synchronous reset clears both outputs.

Top module: `mixed_sign_mul`

## Requirements
- R1: With both signedness flags high (1 = signed), the result is the two's-complement product of the two operands, truncated to 32 bits.
- R2: With both flags low (0 = unsigned), the result is the unsigned product of the two operands.
- R3: With `aSigned`=1 and `bSigned`=0, the result is the product of A as a signed value and B as an unsigned value, as a 32-bit two's-complement number.
- R4: With `aSigned`=0 and `bSigned`=1, the result is the product of A as an unsigned value and B as a signed value, as a 32-bit two's-complement number.
- R5: When `reqValid` is high at a clock edge, `product` and `prodValid`=1 appear after that edge. Back-to-back requests give one result per cycle.
- R6: When `reqValid` is low at a clock edge, `prodValid` is 0 after that edge.
- R7: When `reqValid` is low, the operands and flags are ignored and `product` keeps its previous value.
- R8: When `rst` is high at a clock edge, `product` becomes 0 and `prodValid` becomes 0.
- R9: The full-scale corners are exact:
  - 0x8000 times 0x8000 signed gives 0x40000000.
  - 0xFFFF times 0xFFFF unsigned gives 0xFFFE0001.
  - 0x8000 signed times 0xFFFF unsigned gives 0x80008000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request strobe: multiply this cycle's operands |
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand |
| aSigned | input | 1 | 1: opA is two's complement; 0: opA is unsigned |
| bSigned | input | 1 | 1: opB is two's complement; 0: opB is unsigned |
| product | output | 32 | Registered product |
| prodValid | output | 1 | High for the cycle after each request |

## Verification
The assertions assume that `reqValid`, the operands and the flags are known and stable at every rising edge outside reset. They also assume that reset is held for at least one edge before the first request. The bench drives every input at the falling edge, so each value is settled well before the rising edge that samples it. It starts with reset asserted across several edges. It raises reset again mid-run only at a falling edge, which keeps the inputs inside those assumptions.

// File: rtl/mixmul_pkg.sv
package mixmul_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture a new product
    logic clear;  // zero the product register
  } mulStrobe_t;
endpackage

// File: rtl/mixmul_ext.sv
module mixmul_ext #(
  parameter int unsigned OP_W = 16
) (
  input  logic [OP_W-1:0] data,
  input  logic            isSigned,
  output logic [OP_W:0]   wide
);
  // one extra bit: a copy of the top bit when signed, zero otherwise
  assign wide = {isSigned & data[OP_W-1], data};
endmodule

// File: rtl/mixmul_ctrl.sv
module mixmul_ctrl
  import mixmul_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  output mulStrobe_t strobes,
  output logic       validQ
);
  always_comb begin
    strobes.clear = rst;
    strobes.load  = reqValid & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) validQ <= 1'b0;
    else     validQ <= reqValid;
  end
endmodule

// File: rtl/mixmul_dp.sv
module mixmul_dp
  import mixmul_pkg::*;
#(
  parameter int unsigned OP_W = 16
) (
  input  logic                clk,
  input  mulStrobe_t          strobes,
  input  logic [OP_W-1:0]     opA,
  input  logic [OP_W-1:0]     opB,
  input  logic                aSigned,
  input  logic                bSigned,
  output logic [2*OP_W-1:0]   prodQ
);
  localparam int unsigned EXT_W  = OP_W + 1;
  localparam int unsigned PROD_W = 2 * OP_W;

  logic [OP_W-1:0]  opArr   [2];
  logic             sgnArr  [2];
  logic [EXT_W-1:0] wideArr [2];

  assign opArr[0]  = opA;
  assign opArr[1]  = opB;
  assign sgnArr[0] = aSigned;
  assign sgnArr[1] = bSigned;

  for (genvar gi = 0; gi < 2; gi++) begin : g_ext
    mixmul_ext #(.OP_W(OP_W)) u_ext (
      .data    (opArr[gi]),
      .isSigned(sgnArr[gi]),
      .wide    (wideArr[gi])
    );
  end

  logic signed [EXT_W-1:0] extA, extB;
  logic [PROD_W-1:0]       prodNext;

  assign extA = $signed(wideArr[0]);
  assign extB = $signed(wideArr[1]);
  // full signed product truncated to the architectural width
  assign prodNext = PROD_W'(extA * extB);

  always_ff @(posedge clk) begin
    if (strobes.clear)     prodQ <= '0;
    else if (strobes.load) prodQ <= prodNext;
  end
endmodule

// File: rtl/mixed_sign_mul.sv
module mixed_sign_mul
  import mixmul_pkg::*;
#(
  parameter int unsigned OP_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reqValid,
  input  logic [OP_W-1:0]     opA,
  input  logic [OP_W-1:0]     opB,
  input  logic                aSigned,
  input  logic                bSigned,
  output logic [2*OP_W-1:0]   product,
  output logic                prodValid
);
  mulStrobe_t strobes;

  mixmul_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .reqValid(reqValid),
    .strobes (strobes),
    .validQ  (prodValid)
  );

  mixmul_dp #(.OP_W(OP_W)) u_dp (
    .clk    (clk),
    .strobes(strobes),
    .opA    (opA),
    .opB    (opB),
    .aSigned(aSigned),
    .bSigned(bSigned),
    .prodQ  (product)
  );
endmodule

// File: rtl/mixmul_chk.sv
module mixmul_chk #(
  parameter int unsigned OP_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic [OP_W-1:0]   opA,
  input logic [OP_W-1:0]   opB,
  input logic              aSigned,
  input logic              bSigned,
  input logic [2*OP_W-1:0] product,
  input logic              prodValid
);
  longint refA, refB, refFull;
  logic [2*OP_W-1:0] refLow;

  always_comb begin
    refA    = aSigned ? longint'($signed(opA)) : longint'(opA);
    refB    = bSigned ? longint'($signed(opB)) : longint'(opB);
    refFull = refA * refB;
    refLow  = refFull[2*OP_W-1:0];
  end

  // R1 R2 R3 R4 R9: registered product matches a wide integer reference
  assert_product_exact_R1: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> product == $past(refLow));
  assert_valid_follows_R5: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> prodValid);
  assert_valid_drops_R6: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> !prodValid);
  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> $stable(product));
  assert_reset_clears_R8: assert property (@(posedge clk)
    rst |=> (product == '0) && !prodValid);
endmodule

bind mixed_sign_mul mixmul_chk #(.OP_W(OP_W)) u_chk (
  .clk(clk), .rst(rst), .reqValid(reqValid), .opA(opA), .opB(opB),
  .aSigned(aSigned), .bSigned(bSigned), .product(product), .prodValid(prodValid)
);

// File: tb/mixed_sign_mul_bench.sv
module mixed_sign_mul_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic [15:0] opA = '0, opB = '0;
  logic        aSigned = 1'b0, bSigned = 1'b0;
  logic [31:0] product;
  logic        prodValid;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  mixed_sign_mul u_mixed_sign_mul (
    .clk(clk), .rst(rst), .reqValid(reqValid), .opA(opA), .opB(opB),
    .aSigned(aSigned), .bSigned(bSigned), .product(product), .prodValid(prodValid)
  );

  // {a, b, aSigned, bSigned}
  localparam logic [33:0] VECS [16] = '{
    {16'h8000, 16'h8000, 1'b1, 1'b1},
    {16'h7FFF, 16'h8000, 1'b1, 1'b1},
    {16'hFFFF, 16'hFFFF, 1'b1, 1'b1},
    {16'h0000, 16'h8000, 1'b1, 1'b1},
    {16'h1234, 16'hFEDC, 1'b1, 1'b1},
    {16'hFFFF, 16'hFFFF, 1'b0, 1'b0},
    {16'h8000, 16'h8000, 1'b0, 1'b0},
    {16'h7FFF, 16'hFFFF, 1'b0, 1'b0},
    {16'h0000, 16'hFFFF, 1'b0, 1'b0},
    {16'h8000, 16'hFFFF, 1'b1, 1'b0},
    {16'hFFFF, 16'hFFFF, 1'b1, 1'b0},
    {16'h7FFF, 16'hFFFF, 1'b1, 1'b0},
    {16'h8000, 16'h0001, 1'b1, 1'b0},
    {16'hFFFF, 16'h8000, 1'b0, 1'b1},
    {16'hFFFF, 16'hFFFF, 1'b0, 1'b1},
    {16'h0001, 16'h8000, 1'b0, 1'b1}
  };

  function automatic logic [31:0] refProd(logic [15:0] a, logic [15:0] b, logic sa, logic sb);
    longint x, y, p;
    x = sa ? longint'($signed(a)) : longint'(a);
    y = sb ? longint'($signed(b)) : longint'(b);
    p = x * y;
    return p[31:0];
  endfunction

  function automatic string reqTag(logic sa, logic sb);
    if (sa && sb) return "R1";
    if (!sa && !sb) return "R2";
    if (sa) return "R3";
    return "R4";
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic request(logic [15:0] a, logic [15:0] b, logic sa, logic sb);
    @(negedge clk);
    opA = a; opB = b; aSigned = sa; bSigned = sb; reqValid = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    logic [31:0] held;
    repeat (3) @(posedge clk);
    #1;
    check("R8 reset product", product, 32'h0);
    check("R8 reset valid", {31'b0, prodValid}, 32'h1 & 32'h0);
    @(negedge clk); rst = 1'b0;

    // back-to-back table walk: R1..R4, R5
    foreach (VECS[i]) begin
      logic [15:0] a, b; logic sa, sb;
      {a, b, sa, sb} = VECS[i];
      request(a, b, sa, sb);
      check(reqTag(sa, sb), product, refProd(a, b, sa, sb));
      check("R5 valid", {31'b0, prodValid}, 32'h1);
    end

    // R9 literal corners
    request(16'h8000, 16'h8000, 1'b1, 1'b1);
    check("R9 signed min*min", product, 32'h40000000);
    request(16'hFFFF, 16'hFFFF, 1'b0, 1'b0);
    check("R9 unsigned max*max", product, 32'hFFFE0001);
    request(16'h8000, 16'hFFFF, 1'b1, 1'b0);
    check("R9 mixed corner", product, 32'h80008000);
    held = product;

    // R6 R7: idle cycles with changing operands
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      reqValid = 1'b0; opA = 16'h1111 * 16'(k + 1); opB = 16'h7FFF; aSigned = k[0]; bSigned = 1'b1;
      @(posedge clk); #1;
      check("R6 valid low", {31'b0, prodValid}, 32'h0);
      check("R7 product held", product, held);
    end

    // R5 after idle
    request(16'h0003, 16'hFFFE, 1'b0, 1'b1);
    check("R5 product after idle", product, 32'hFFFFFFFA);
    check("R5 valid after idle", {31'b0, prodValid}, 32'h1);

    // R8 mid-run reset with a request present
    @(negedge clk); rst = 1'b1; reqValid = 1'b1; opA = 16'h7FFF; opB = 16'h7FFF;
    @(posedge clk); #1;
    check("R8 mid reset product", product, 32'h0);
    check("R8 mid reset valid", {31'b0, prodValid}, 32'h0);
    @(negedge clk); rst = 1'b0; reqValid = 1'b0;
    request(16'h7FFF, 16'h7FFF, 1'b1, 1'b1);
    check("R1 after reset", product, 32'h3FFF0001);
    @(negedge clk); reqValid = 1'b0;
    finished = 1'b1;
    finishRun();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finishRun();
    end
  end
endmodule